// File: doc/BRIEF.md
# Multi-Policy Bus Arbiter

This block decides which of several bus masters owns a shared bus. Every master has a request line, a grant line and an acknowledge line. When the arbiter is idle and at least one master is requesting, it grants the bus to exactly one requester. The grant stays in place until that master has acknowledged it and then lowered its request. After that the arbiter goes idle again and arbitrates anew.

A run-time mode input chooses how the winner is picked. Fixed priority always prefers the lowest master index. Rotating priority keeps a pointer to the master that currently holds top priority and moves that pointer by one place after each completed grant, so each master passes through every priority level in turn. Random choice draws a start index from a 16-bit maximal-length LFSR and takes the first requesting master at or after that index in circular order. The winner is therefore always one of the masters that is requesting at that moment.

Top module: `bus_arbiter`

## Requirements
- R1: After reset, no grant is driven and the rotating pointer gives master 0 top priority.
- R2: At most one grant bit is high in any cycle. A new grant goes only to a master whose request was high in the cycle it was sampled.
- R3: While no master requests, no grant is driven.
- R4: With mode 2'b00 or 2'b11 (fixed), the requesting master with the lowest index wins.
- R5: With mode 2'b01 (rotating), the winner is the first requester found by scanning upward and circularly from the pointer. The pointer moves up by one (wrapping) after each completed grant that was issued in this mode.
- R6: With mode 2'b10 (random), the winner is always one of the current requesters. When only one master requests, that master wins.
- R7: While the owner keeps its request high, the grant does not change, whatever the acknowledge and the other requests do.
- R8: A grant appears one cycle after the request is sampled. Once the owner has acknowledged and then drops its request, the grant is removed at the next edge.
- R9: If the owner drops its request before acknowledging, the grant is withdrawn at the next edge and the rotating pointer does not move.
- R10: In rotating mode with all masters requesting, any N consecutive completed grants go to N different masters, so no master is starved.
- R11: Grants completed in fixed or random mode leave the rotating pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Policy: 00 fixed, 01 rotating, 10 random, 11 fixed |
| req_i | input | NUM_M | Request line per master |
| ack_i | input | NUM_M | Grant acknowledge line per master |
| gnt_o | output | NUM_M | Grant line per master, at most one high |

## Verification
A request that is set up before an edge is sampled at that edge, and the grant is visible just after it. The monitor therefore samples on the falling edge that follows and matches every new grant against the item the driver queued for that round. An acknowledge moves the FSM to the owned state at the next edge. A release clears the grant one edge later, so each release check is made on the falling edge after that clearing edge. The hold and withdraw checks are made on falling edges between the rising edges that could change the grant, so a change caused by one stimulus is never mistaken for the effect of another.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        POL_FIXED  = 2'b00,
        POL_ROTATE = 2'b01,
        POL_RANDOM = 2'b10,
        POL_ALT    = 2'b11
    } policy_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_OFFER = 2'b01,
        ST_OWNED = 2'b10
    } arb_state_e;

endpackage

// File: rtl/arb_lfsr.sv
module arb_lfsr #(
    parameter int          LFSR_W = 16,
    parameter logic [15:0] TAPS   = 16'hB400,
    parameter logic [15:0] SEED   = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [LFSR_W-1:0] state_o
);
    logic [LFSR_W-1:0] lfsr_d, lfsr_q;

    // Galois form: shift right, fold the taps in when the outgoing bit is set.
    always_comb begin
        lfsr_d = {1'b0, lfsr_q[LFSR_W-1:1]};
        if (lfsr_q[0]) begin
            lfsr_d = lfsr_d ^ TAPS[LFSR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= SEED[LFSR_W-1:0];
        else        lfsr_q <= lfsr_d;
    end

    assign state_o = lfsr_q;
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
    parameter int NUM_M = 4,
    localparam int IDXW = (NUM_M > 1) ? $clog2(NUM_M) : 1
) (
    input  logic [NUM_M-1:0] req_i,
    input  logic [IDXW-1:0]  start_i,
    output logic [NUM_M-1:0] win_o
);
    // Circular scan: first requester at or after start_i.
    always_comb begin
        logic found;
        win_o = '0;
        found = 1'b0;
        for (int k = 0; k < NUM_M; k++) begin
            int unsigned j;
            j = (int'(start_i) + k) % NUM_M;
            if (!found && req_i[j]) begin
                win_o[j] = 1'b1;
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
    import arb_pkg::*;
#(
    parameter int NUM_M  = 4,
    parameter int LFSR_W = 16,
    localparam int IDXW  = (NUM_M > 1) ? $clog2(NUM_M) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic [NUM_M-1:0] req_i,
    input  logic [NUM_M-1:0] ack_i,
    output logic [NUM_M-1:0] gnt_o
);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NUM_M - 1);

    typedef struct packed {
        arb_state_e       state;
        logic [NUM_M-1:0] gnt;
        logic [IDXW-1:0]  ptr;
        logic             rot;   // grant was issued under rotating policy
    } arb_regs_t;

    arb_regs_t cur_q, nxt_d;

    logic [LFSR_W-1:0] lfsr;
    logic [IDXW-1:0]   rnd_idx;
    logic [IDXW-1:0]   start;
    logic [NUM_M-1:0]  win;
    policy_e           pol;

    arb_lfsr #(.LFSR_W(LFSR_W)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_o (lfsr)
    );

    assign rnd_idx = IDXW'(lfsr % LFSR_W'(NUM_M));
    assign pol     = policy_e'(mode_i);

    always_comb begin
        case (pol)
            POL_ROTATE: start = cur_q.ptr;
            POL_RANDOM: start = rnd_idx;
            default:    start = '0;
        endcase
    end

    arb_pick #(.NUM_M(NUM_M)) u_pick (
        .req_i   (req_i),
        .start_i (start),
        .win_o   (win)
    );

    always_comb begin
        nxt_d = cur_q;
        case (cur_q.state)
            ST_IDLE: begin
                if (req_i != '0) begin
                    nxt_d.gnt   = win;
                    nxt_d.rot   = (pol == POL_ROTATE);
                    nxt_d.state = ST_OFFER;
                end
            end
            ST_OFFER: begin
                if ((cur_q.gnt & req_i) == '0) begin
                    // withdrawn before acknowledge: no rotation
                    nxt_d.gnt   = '0;
                    nxt_d.state = ST_IDLE;
                end else if ((cur_q.gnt & ack_i) != '0) begin
                    nxt_d.state = ST_OWNED;
                end
            end
            ST_OWNED: begin
                if ((cur_q.gnt & req_i) == '0) begin
                    nxt_d.gnt   = '0;
                    nxt_d.state = ST_IDLE;
                    if (cur_q.rot) begin
                        nxt_d.ptr = (cur_q.ptr == LAST_IDX) ? '0 : cur_q.ptr + 1'b1;
                    end
                end
            end
            default: begin
                nxt_d.gnt   = '0;
                nxt_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state <= ST_IDLE;
            cur_q.gnt   <= '0;
            cur_q.ptr   <= '0;
            cur_q.rot   <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign gnt_o = cur_q.gnt;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
    parameter int NUM_M = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_i,
    input logic [NUM_M-1:0] req_i,
    input logic [NUM_M-1:0] ack_i,
    input logic [NUM_M-1:0] gnt_o
);
    assert_onehot_gnt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    assert_gnt_to_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o == '0) |=> ((gnt_o & ~$past(req_i)) == '0));

    assert_no_req_no_gnt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o == '0 && req_i == '0) |=> (gnt_o == '0));

    assert_fixed_lowest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o == '0 && mode_i == 2'b00 && req_i != '0)
        |=> (gnt_o == ($past(req_i) & (~$past(req_i) + 1'b1))));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_o & req_i) != '0) |=> $stable(gnt_o));

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0 && (gnt_o & req_i) == '0) |=> (gnt_o == '0));

    logic unused_ack;
    assign unused_ack = ^ack_i;
endmodule

bind bus_arbiter arb_checker #(.NUM_M(NUM_M)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_i),
    .req_i  (req_i),
    .ack_i  (ack_i),
    .gnt_o  (gnt_o)
);

// File: tb/bus_arbiter_tb.sv
module bus_arbiter_tb;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [1:0]   mode;
    logic [N-1:0] req, ack;
    logic [N-1:0] gnt;

    always #5 clk = ~clk;

    bus_arbiter #(.NUM_M(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .req_i(req), .ack_i(ack), .gnt_o(gnt)
    );

    typedef struct {
        logic [N-1:0] allow;
        string        tag;
    } exp_t;

    exp_t   sb[$];
    int     checks = 0;
    int     errors = 0;
    int     ptr_m  = 0;
    bit     done   = 1'b0;
    logic [N-1:0] prev_gnt = '0;

    task automatic check(input bit ok, input string tag,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] fixed_win(input logic [N-1:0] r);
        for (int i = 0; i < N; i++) if (r[i]) return N'(1) << i;
        return '0;
    endfunction

    function automatic logic [N-1:0] rot_win(input logic [N-1:0] r, input int p);
        for (int k = 0; k < N; k++) if (r[(p + k) % N]) return N'(1) << ((p + k) % N);
        return '0;
    endfunction

    // monitor: pops the scoreboard on each new grant
    always @(negedge clk) begin
        if (rst_n && gnt != '0 && prev_gnt == '0) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2 unexpected grant", gnt, '0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check($onehot(gnt) && ((gnt & ~e.allow) == '0), e.tag, gnt, e.allow);
            end
        end
        prev_gnt = gnt;
    end

    task automatic wait_grant(output int owner);
        owner = -1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (gnt != '0) break;
        end
        for (int i = 0; i < N; i++) if (gnt[i]) owner = i;
        if (owner < 0) check(1'b0, "R8 grant timeout", gnt, '1);
    endtask

    task automatic round(input logic [N-1:0] r, input logic [1:0] m,
                         input logic [N-1:0] allow, input string tag, output int owner);
        @(negedge clk);
        mode = m;
        req  = r;
        sb.push_back('{allow, tag});
        wait_grant(owner);
        if (owner >= 0) ack[owner] = 1'b1;
        @(negedge clk);
        ack = '0;
        req = '0;
        @(negedge clk);
        check(gnt == '0, "R8 release", gnt, '0);
        if (m == 2'b01) ptr_m = (ptr_m + 1) % N;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            check(1'b0, "watchdog", gnt, '0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int owner;
        int cnt[N];
        logic [N-1:0] held;
        rst_n = 1'b0; req = '0; ack = '0; mode = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(gnt == '0, "R1 reset grant", gnt, '0);
        repeat (3) @(negedge clk);
        check(gnt == '0, "R3 idle no grant", gnt, '0);

        // fixed priority
        round(4'b1111, 2'b00, fixed_win(4'b1111), "R4 fixed all", owner);
        round(4'b1100, 2'b00, fixed_win(4'b1100), "R4 fixed upper", owner);
        round(4'b1010, 2'b00, fixed_win(4'b1010), "R4 fixed odd", owner);
        round(4'b1000, 2'b11, fixed_win(4'b1000), "R4 mode 11", owner);

        // rotating, all requesting: fairness
        foreach (cnt[i]) cnt[i] = 0;
        for (int n = 0; n < 2 * N; n++) begin
            round(4'b1111, 2'b01, rot_win(4'b1111, ptr_m), "R5 rotate all", owner);
            if (owner >= 0) cnt[owner]++;
        end
        for (int i = 0; i < N; i++) check(cnt[i] == 2, "R10 no starvation", N'(cnt[i]), N'(2));
        round(4'b0101, 2'b01, rot_win(4'b0101, ptr_m), "R5 rotate subset", owner);
        round(4'b0011, 2'b01, rot_win(4'b0011, ptr_m), "R5 rotate subset2", owner);

        // hold while owner requests
        @(negedge clk);
        mode = 2'b01; req = 4'b1111;
        sb.push_back('{rot_win(4'b1111, ptr_m), "R7 hold grant"});
        wait_grant(owner);
        held = gnt;
        for (int c = 0; c < 3; c++) begin
            req = held | (N'(c + 5) & ~held);
            @(negedge clk);
            check(gnt == held, "R7 hold under req change", gnt, held);
        end
        if (owner >= 0) ack[owner] = 1'b1;
        @(negedge clk);
        ack = '0;
        @(negedge clk);
        check(gnt == held, "R7 hold after ack", gnt, held);
        req = '0;
        @(negedge clk);
        check(gnt == '0, "R8 release after hold", gnt, '0);
        ptr_m = (ptr_m + 1) % N;

        // withdraw before ack
        @(negedge clk);
        mode = 2'b01; req = 4'b1111;
        sb.push_back('{rot_win(4'b1111, ptr_m), "R9 offered"});
        wait_grant(owner);
        req = '0;
        @(negedge clk);
        check(gnt == '0, "R9 withdrawn", gnt, '0);
        round(4'b1111, 2'b01, rot_win(4'b1111, ptr_m), "R9 pointer kept", owner);

        // random
        foreach (cnt[i]) cnt[i] = 0;
        for (int n = 0; n < 40; n++) begin
            round(4'b1111, 2'b10, 4'b1111, "R6 random all", owner);
            if (owner >= 0) cnt[owner]++;
        end
        for (int i = 0; i < N; i++) check(cnt[i] > 0, "R6 random spread", N'(cnt[i]), N'(1));
        round(4'b0010, 2'b10, 4'b0010, "R6 random single", owner);
        round(4'b1001, 2'b10, 4'b1001, "R6 random pair", owner);

        // fixed and random left the pointer alone
        round(4'b1111, 2'b01, rot_win(4'b1111, ptr_m), "R11 pointer unmoved", owner);

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R2 scoreboard drained", N'(sb.size()), '0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule